// File: doc/BRIEF.md
# Relocatable Control-Register Window Decoder

This block decodes bus accesses that land in a 256-byte window of 16-bit control and status registers. The window can sit in either the 20-bit memory space or the 16-bit I/O space. One register inside the window holds the window's own base address and its space select. Writing that register moves the window, and the move applies from the very next clock cycle. A small bank of plain read/write registers stands in for the peripherals that would normally sit behind the window.

Decode is combinational within one cycle. When a read or write strobe is high, the block reports whether the access hits the window. It also gives the byte offset inside the window and, for reads, the selected register's contents. Writes commit on the rising clock edge. Every access completes in the cycle it is presented, so the block never applies back-pressure. Strobes and qualifiers are plain level signals with no handshake.

Top module: `pcb_decoder`

## Requirements
- R1: After reset, the relocation register reads 0x00FF. The window is in I/O space at 0xFF00–0xFFFF, the relocation word is at I/O address 0xFFFE, and every stand-in register reads 0x0000.
- R2: `hit` is high only when all of these hold: `bus_rd` or `bus_wr` is high, the space matches, the base bits match, and `bus_addr[0]` is 0. Odd addresses never hit.
- R3: `reg_sel` equals `bus_addr[7:0]` while `hit` is high, and is 0x00 otherwise.
- R4: While `hit` and `bus_rd` are both high, `rdata` shows the addressed register. At all other times `rdata` is 0x0000.
- R5: A write that hits a stand-in register stores `bus_wdata` at the rising edge. The value reads back on later cycles, and other registers keep their values.
- R6: An access that misses changes no register. A miss can come from the wrong space, the wrong base, an odd address or no strobe.
- R7: Relocation register layout:
  - bits [11:0] give the base, matched against address bits [19:8];
  - bit 12 selects the space (1 = memory, 0 = I/O);
  - bits [15:13] ignore writes and read as zero.
- R8: A write to offset 0xFE moves the window from the next cycle. After the move, the old base misses and the new base hits.
- R9: In I/O space (`bus_io` = 1), only `bus_addr[15:8]` is compared, against relocation bits [7:0]. `bus_addr[19:16]` and relocation bits [11:8] are ignored.
- R10: In memory space (`bus_io` = 0), `bus_addr[19:8]` is compared against relocation bits [11:0]. An access to the other space misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 20 | Byte address (I/O uses bits 15:0) |
| bus_io | input | 1 | 1 = I/O space access, 0 = memory access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| hit | output | 1 | Access falls inside the window |
| reg_sel | output | 8 | Byte offset within the window, zero on a miss |
| rdata | output | 16 | Read data, zero unless a read hits |

## Verification
The bench rewrites the relocation register and reads at the new base on the very next cycle. A design that registered the decode base late would miss there, or still answer at the old base. It switches the window from I/O to memory and back, with junk in the ignored address and relocation bits. A decoder that compared too many bits, or the wrong ones, would miss where it should hit. Writes to the wrong space, the wrong base and odd addresses are each followed by a read-back of the target register. That read-back would expose a write enable that ignores the space or alignment check.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
package pcb_pkg;
  localparam int MEM_AW    = 20;
  localparam int IO_AW     = 16;
  localparam int WIN_LOG2  = 8;
  localparam int DATA_W    = 16;
  localparam int BASE_W    = MEM_AW - WIN_LOG2;
  localparam int IO_BASE_W = IO_AW - WIN_LOG2;
  localparam int LANE_LOG2 = $clog2(DATA_W / 8);
  localparam int IDX_W     = WIN_LOG2 - LANE_LOG2;
  localparam int NWORDS    = 1 << IDX_W;
  localparam int RELOC_W   = BASE_W + 1;

  typedef struct packed {
    logic              mem_space;
    logic [BASE_W-1:0] base;
  } pcb_reloc_t;
endpackage

// File: rtl/pcb_window_match.sv
`timescale 1ns/1ps
module pcb_window_match
  import pcb_pkg::*;
(
  input  logic [MEM_AW-1:0]   addr,
  input  logic                is_io,
  input  logic                rd,
  input  logic                wr,
  input  pcb_reloc_t          reloc,
  output logic                hit,
  output logic [WIN_LOG2-1:0] offset
);
  logic space_ok, base_ok, aligned;

  always_comb begin
    if (reloc.mem_space) begin
      space_ok = !is_io;
      base_ok  = (addr[MEM_AW-1:WIN_LOG2] == reloc.base);
    end else begin
      space_ok = is_io;
      base_ok  = (addr[IO_AW-1:WIN_LOG2] == reloc.base[IO_BASE_W-1:0]);
    end
    aligned = (addr[LANE_LOG2-1:0] == '0);
    hit     = (rd || wr) && space_ok && base_ok && aligned;
    offset  = hit ? addr[WIN_LOG2-1:0] : '0;
  end
endmodule

// File: rtl/pcb_reloc_reg.sv
`timescale 1ns/1ps
module pcb_reloc_reg
  import pcb_pkg::*;
#(
  parameter pcb_reloc_t RESET_VAL = '{mem_space: 1'b0, base: 12'h0FF}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RELOC_W-1:0] wdata,
  output pcb_reloc_t         reloc,
  output logic [DATA_W-1:0]  rd_word
);
  pcb_reloc_t reloc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     reloc_q <= RESET_VAL;
    else if (wr_en) reloc_q <= pcb_reloc_t'(wdata);
  end

  assign reloc   = reloc_q;
  assign rd_word = {{(DATA_W-RELOC_W){1'b0}}, reloc_q};
endmodule

// File: rtl/pcb_reg_bank.sv
`timescale 1ns/1ps
module pcb_reg_bank
  import pcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] words [NWORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) words[i] <= '0;
    end else if (wr_en) begin
      words[idx] <= wdata;
    end
  end

  assign rd_word = words[idx];
endmodule

// File: rtl/pcb_decoder.sv
`timescale 1ns/1ps
module pcb_decoder
  import pcb_pkg::*;
#(
  parameter logic [WIN_LOG2-1:0] RELOC_OFF = 8'hFE,
  parameter pcb_reloc_t          RESET_RELOC = '{mem_space: 1'b0, base: 12'h0FF}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MEM_AW-1:0]   bus_addr,
  input  logic                bus_io,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic                hit,
  output logic [WIN_LOG2-1:0] reg_sel,
  output logic [DATA_W-1:0]   rdata
);
  pcb_reloc_t        reloc;
  logic [DATA_W-1:0] reloc_word;
  logic [DATA_W-1:0] bank_word;
  logic              sel_reloc;
  logic              reloc_we, bank_we;

  pcb_window_match u_match (
    .addr   (bus_addr),
    .is_io  (bus_io),
    .rd     (bus_rd),
    .wr     (bus_wr),
    .reloc  (reloc),
    .hit    (hit),
    .offset (reg_sel)
  );

  assign sel_reloc = (reg_sel == RELOC_OFF);
  assign reloc_we  = hit && bus_wr && sel_reloc;
  assign bank_we   = hit && bus_wr && !sel_reloc;

  pcb_reloc_reg #(.RESET_VAL(RESET_RELOC)) u_reloc (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reloc_we),
    .wdata   (bus_wdata[RELOC_W-1:0]),
    .reloc   (reloc),
    .rd_word (reloc_word)
  );

  pcb_reg_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bank_we),
    .idx     (reg_sel[WIN_LOG2-1:LANE_LOG2]),
    .wdata   (bus_wdata),
    .rd_word (bank_word)
  );

  always_comb begin
    if (hit && bus_rd) rdata = sel_reloc ? reloc_word : bank_word;
    else               rdata = '0;
  end
endmodule

// File: rtl/pcb_decoder_chk.sv
`timescale 1ns/1ps
module pcb_decoder_chk
  import pcb_pkg::*;
#(
  parameter logic [WIN_LOG2-1:0] RELOC_OFF = 8'hFE
) (
  input logic                clk,
  input logic                rst_n,
  input logic                addr_lsb,
  input logic                bus_rd,
  input logic                bus_wr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                hit,
  input logic [WIN_LOG2-1:0] reg_sel,
  input logic [DATA_W-1:0]   rdata,
  input logic [DATA_W-1:0]   reloc_word
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'((1 << RELOC_W) - 1);

  p_hit_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (bus_rd || bus_wr));

  p_hit_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !addr_lsb);

  p_sel_zero_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (reg_sel == '0));

  p_rdata_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && bus_rd) |-> (rdata == '0));

  p_reloc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && bus_wr && reg_sel == RELOC_OFF) |=> $stable(reloc_word));

  p_reloc_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reloc_word & ~KEEP) == '0);

  p_reloc_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bus_wr && reg_sel == RELOC_OFF) |=> (reloc_word == ($past(bus_wdata) & KEEP)));
endmodule

bind pcb_decoder pcb_decoder_chk #(.RELOC_OFF(RELOC_OFF)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_lsb   (bus_addr[0]),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .hit        (hit),
  .reg_sel    (reg_sel),
  .rdata      (rdata),
  .reloc_word (reloc_word)
);

// File: tb/tb_pcb_decoder.sv
`timescale 1ns/1ps
module tb_pcb_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] bus_addr = '0;
  logic        bus_io = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        hit;
  logic [7:0]  reg_sel;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pcb_decoder dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_io(bus_io),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .hit(hit), .reg_sel(reg_sel), .rdata(rdata)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic io, input logic [19:0] a, input logic rd,
                       input logic wr, input logic [15:0] wd);
    @(negedge clk);
    bus_io = io; bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    #5;
  endtask

  task automatic idle();
    drive(1'b0, 20'h0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic rd_chk(input string req, input logic io, input logic [19:0] a,
                        input logic exp_hit, input logic [15:0] exp_data);
    drive(io, a, 1'b1, 1'b0, 16'h0);
    check(req, "hit", 32'(hit), 32'(exp_hit));
    check(req, "reg_sel", 32'(reg_sel), exp_hit ? 32'(a[7:0]) : 32'h0);
    check(req, "rdata", 32'(rdata), exp_hit ? 32'(exp_data) : 32'h0);
  endtask

  task automatic wr_chk(input string req, input logic io, input logic [19:0] a,
                        input logic [15:0] d, input logic exp_hit);
    drive(io, a, 1'b0, 1'b1, d);
    check(req, "write hit", 32'(hit), 32'(exp_hit));
    check(req, "write rdata", 32'(rdata), 32'h0);
  endtask

  // R1 R3 R4: reset state
  task automatic t_reset();
    rd_chk("R1", 1'b1, 20'h0FFFE, 1'b1, 16'h00FF);
    rd_chk("R1", 1'b1, 20'h0FF10, 1'b1, 16'h0000);
    rd_chk("R1", 1'b1, 20'h0FF00, 1'b1, 16'h0000);
  endtask

  // R2 R3 R4: no strobe and odd address never hit
  task automatic t_no_hit();
    drive(1'b1, 20'h0FFFE, 1'b0, 1'b0, 16'h0);
    check("R2", "idle hit", 32'(hit), 32'h0);
    check("R3", "idle reg_sel", 32'(reg_sel), 32'h0);
    check("R4", "idle rdata", 32'(rdata), 32'h0);
    rd_chk("R2", 1'b1, 20'h0FFFF, 1'b0, 16'h0);
  endtask

  // R5: stand-in register write and read-back
  task automatic t_bank();
    wr_chk("R5", 1'b1, 20'h0FF10, 16'hA5A5, 1'b1);
    rd_chk("R5", 1'b1, 20'h0FF10, 1'b1, 16'hA5A5);
    wr_chk("R5", 1'b1, 20'h0FF12, 16'h1234, 1'b1);
    rd_chk("R5", 1'b1, 20'h0FF10, 1'b1, 16'hA5A5);
    rd_chk("R5", 1'b1, 20'h0FF12, 1'b1, 16'h1234);
  endtask

  // R6: misses leave registers untouched
  task automatic t_miss();
    wr_chk("R6", 1'b0, 20'h0FF10, 16'hDEAD, 1'b0);
    wr_chk("R6", 1'b1, 20'h0FE10, 16'hBEEF, 1'b0);
    wr_chk("R6", 1'b1, 20'h0FF11, 16'hCAFE, 1'b0);
    wr_chk("R6", 1'b0, 20'h0FFFE, 16'h1000, 1'b0);
    rd_chk("R6", 1'b1, 20'h0FF10, 1'b1, 16'hA5A5);
    rd_chk("R6", 1'b1, 20'h0FFFE, 1'b1, 16'h00FF);
  endtask

  // R9: upper address bits ignored in I/O space
  task automatic t_io_upper();
    rd_chk("R9", 1'b1, 20'hAFF10, 1'b1, 16'hA5A5);
  endtask

  // R7 R8 R10: move into memory space and check the next cycle
  task automatic t_to_mem();
    wr_chk("R8", 1'b1, 20'h0FFFE, 16'hF123, 1'b1);
    rd_chk("R8", 1'b1, 20'h0FFFE, 1'b0, 16'h0);
    rd_chk("R7", 1'b0, 20'h123FE, 1'b1, 16'h1123);
    rd_chk("R10", 1'b0, 20'h12310, 1'b1, 16'hA5A5);
    rd_chk("R10", 1'b0, 20'h02310, 1'b0, 16'h0);
    rd_chk("R10", 1'b1, 20'h02310, 1'b0, 16'h0);
  endtask

  // R8 R9 R7: back to I/O with junk in relocation bits [11:8]
  task automatic t_to_io();
    wr_chk("R8", 1'b0, 20'h123FE, 16'h0A34, 1'b1);
    rd_chk("R9", 1'b1, 20'h534FE, 1'b1, 16'h0A34);
    rd_chk("R9", 1'b1, 20'h03410, 1'b1, 16'hA5A5);
    rd_chk("R8", 1'b0, 20'h123FE, 1'b0, 16'h0);
    rd_chk("R10", 1'b0, 20'h03410, 1'b0, 16'h0);
  endtask

  initial begin
    #50;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_no_hit();
    t_bank();
    t_miss();
    t_io_upper();
    t_to_mem();
    t_to_io();
    idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule